// File: doc/BRIEF.md
# Floppy Controller Command-Loading Handshake

This block runs the host side of loading a command into a floppy disk controller. The host polls a status port and writes bytes to a data port. It may write only while the status shows "ready for a byte, host to controller". The first byte is an opcode. A lookup on its low five bits tells the block how many parameter bytes follow. After each accepted byte the ready bit drops. The byte is absorbed over a fixed internal latency of two clocks. The ready bit then returns if more bytes are due. After the last byte the ready bit stays low and the block hands off to execution.

Each accepted parameter byte goes out on a registered strobe with its index. The handoff is a one-cycle `exec_go` pulse that carries the opcode. The block waits in execution until `exec_done` and then returns to the command phase. An unknown opcode collects no parameters. The block instead flips the direction bit and offers a single invalid-command byte (0x80) on the data port. Reading that byte returns the block to the command phase. The FIFO enable output is held low in every command-phase state.

The states are: ST_IDLE (waiting for an opcode), ST_ABSORB (latency after any accepted byte), ST_PARAM (waiting for a parameter), ST_EXEC (execution handoff) and ST_INVAL (invalid byte pending). The transitions are:
- ST_IDLE to ST_ABSORB on an accepted write.
- ST_ABSORB, once the latency ends, to ST_INVAL (bad opcode), to ST_EXEC (no bytes remaining) or to ST_PARAM (more bytes due).
- ST_PARAM to ST_ABSORB on an accepted write.
- ST_EXEC to ST_IDLE on `exec_done`.
- ST_INVAL to ST_IDLE on a data-port read.

Top module: `fdc_cmd_handshake`

## Requirements
- R1: After reset the status port reads 0x80. Status bit 7 is ready, bit 6 is direction (1 = controller to host), bit 5 is non-DMA execution, bit 4 is busy, and bits 3..0 are 0.
- R2: A write is accepted only at data port address 1 while ready=1 and direction=0. Writes to address 0, and writes at any other time, leave the parameter stream, the handoff and the status unchanged.
- R3: In the clock after an accepted write, ready reads 0 and busy reads 1.
- R4: Ready stays 0 for exactly two clocks after an accepted write. When more bytes are due it then reads 1 again, with status 0x90.
- R5: The parameter count is looked up from opcode bits 4..0 (bits 7..5 are ignored): 0x03→2, 0x04→1, 0x05→8, 0x06→8, 0x07→1, 0x08→0, 0x0F→2, 0x13→3. Every other code is invalid. Each accepted parameter appears once, in order, on `parm_stb`/`parm_data`/`parm_idx` in the clock after it is written.
- R6: After the last parameter is absorbed, ready stays 0. `exec_go` pulses for one clock with `exec_opcode` equal to the full opcode byte, and the status reads 0x10 while `nondma_mode`=0.
- R7: `fifo_allow` is 0 in every command-phase state and 1 only during execution.
- R8: During execution, status bit 5 follows `nondma_mode`, so the status reads 0x30 when it is 1.
- R9: An invalid opcode collects no parameters and produces no `exec_go`. After the latency the status reads 0xD0 and the data port reads 0x80. That read returns the status to 0x80.
- R10: `exec_done` during execution returns the status to 0x80.
- R11: A valid opcode with zero parameters goes straight to execution after its latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_addr | input | 1 | 0 = status port, 1 = data port |
| hst_rd | input | 1 | Host read strobe |
| hst_wr | input | 1 | Host write strobe |
| hst_wdata | input | 8 | Host write data |
| hst_rdata | output | 8 | Read data for the addressed port |
| nondma_mode | input | 1 | Execution will run without DMA |
| exec_done | input | 1 | Execution finished, return to command phase |
| exec_go | output | 1 | One-clock handoff pulse |
| exec_opcode | output | 8 | Opcode of the handed-off command |
| parm_stb | output | 1 | Parameter byte valid |
| parm_data | output | 8 | Parameter byte |
| parm_idx | output | 4 | Parameter position, starting at 0 |
| fifo_allow | output | 1 | Data FIFO may be enabled |

## Verification
A wrong state shows at the status port within a clock or two. A counter that ends early or late makes ready return too soon or too late, or never. A miscounted parameter total makes the parameter stream too short or too long, or misplaces the `exec_go` pulse. A missed invalid-opcode decode leaves direction at 0 where 0xD0 was due. The parameter stream is compared byte by byte against the bytes written. Because of that, a write that should have been ignored shows up as an extra or shifted byte before the next handoff.

// File: rtl/fdc_hs_pkg.sv
package fdc_hs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ABSORB,
        ST_PARAM,
        ST_EXEC,
        ST_INVAL
    } hs_state_t;

    localparam logic [7:0] INVALID_BYTE = 8'h80;

    // returns {valid, count[3:0]}
    function automatic logic [4:0] param_need(input logic [4:0] op);
        logic [4:0] r;
        unique case (op)
            5'h03:   r = {1'b1, 4'd2};
            5'h04:   r = {1'b1, 4'd1};
            5'h05:   r = {1'b1, 4'd8};
            5'h06:   r = {1'b1, 4'd8};
            5'h07:   r = {1'b1, 4'd1};
            5'h08:   r = {1'b1, 4'd0};
            5'h0F:   r = {1'b1, 4'd2};
            5'h13:   r = {1'b1, 4'd3};
            default: r = {1'b0, 4'd0};
        endcase
        return r;
    endfunction
endpackage

// File: rtl/hs_bus_decode.sv
module hs_bus_decode #(
    parameter int DW = 8
) (
    input  logic          hst_addr,
    input  logic          hst_rd,
    input  logic          hst_wr,
    input  logic          rqm,
    input  logic          dio,
    input  logic [DW-1:0] status_byte,
    input  logic [DW-1:0] data_byte,
    output logic          wr_acc,
    output logic          rd_acc,
    output logic [DW-1:0] rdata
);
    always_comb begin
        wr_acc = hst_wr && hst_addr && rqm && !dio;
        rd_acc = hst_rd && hst_addr && rqm && dio;
        rdata  = hst_addr ? (dio ? data_byte : '0) : status_byte;
    end
endmodule

// File: rtl/hs_latency.sv
module hs_latency #(
    parameter int LAT = 2,
    localparam int CW = (LAT > 1) ? $clog2(LAT) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic done
);
    logic [CW-1:0] cnt;

    assign done = active && (cnt == CW'(LAT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt <= '0;
        else if (!active || done) cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/fdc_cmd_handshake.sv
module fdc_cmd_handshake
    import fdc_hs_pkg::*;
#(
    parameter int LAT  = 2,
    parameter int DW   = 8,
    parameter int IDXW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hst_addr,
    input  logic            hst_rd,
    input  logic            hst_wr,
    input  logic [DW-1:0]   hst_wdata,
    output logic [DW-1:0]   hst_rdata,
    input  logic            nondma_mode,
    input  logic            exec_done,
    output logic            exec_go,
    output logic [DW-1:0]   exec_opcode,
    output logic            parm_stb,
    output logic [DW-1:0]   parm_data,
    output logic [IDXW-1:0] parm_idx,
    output logic            fifo_allow
);
    hs_state_t       state, nxt;
    logic            rqm, dio, busy, ndm;
    logic            wr_acc, rd_acc, lat_done, first_byte;
    logic [IDXW-1:0] remain, idx;
    logic [4:0]      need;
    logic [DW-1:0]   status_byte;

    assign need        = param_need(exec_opcode[4:0]);
    assign status_byte = {rqm, dio, ndm, busy, {(DW-4){1'b0}}};

    hs_bus_decode #(.DW(DW)) u_dec (
        .hst_addr    (hst_addr),
        .hst_rd      (hst_rd),
        .hst_wr      (hst_wr),
        .rqm         (rqm),
        .dio         (dio),
        .status_byte (status_byte),
        .data_byte   (INVALID_BYTE),
        .wr_acc      (wr_acc),
        .rd_acc      (rd_acc),
        .rdata       (hst_rdata)
    );

    hs_latency #(.LAT(LAT)) u_lat (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (state == ST_ABSORB),
        .done   (lat_done)
    );

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (wr_acc) nxt = ST_ABSORB;
            ST_ABSORB: if (lat_done) begin
                if (first_byte) begin
                    if (!need[4])              nxt = ST_INVAL;
                    else if (need[3:0] == '0)  nxt = ST_EXEC;
                    else                       nxt = ST_PARAM;
                end else if (remain == '0)     nxt = ST_EXEC;
                else                           nxt = ST_PARAM;
            end
            ST_PARAM:  if (wr_acc) nxt = ST_ABSORB;
            ST_EXEC:   if (exec_done) nxt = ST_IDLE;
            ST_INVAL:  if (rd_acc) nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // state register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            first_byte  <= 1'b0;
            remain      <= '0;
            idx         <= '0;
            exec_opcode <= '0;
            exec_go     <= 1'b0;
            parm_stb    <= 1'b0;
            parm_data   <= '0;
            parm_idx    <= '0;
        end else begin
            state    <= nxt;
            exec_go  <= (state == ST_ABSORB) && (nxt == ST_EXEC);
            parm_stb <= 1'b0;
            if (state == ST_IDLE && wr_acc) begin
                exec_opcode <= hst_wdata;
                first_byte  <= 1'b1;
            end
            if (state == ST_ABSORB && lat_done && first_byte) begin
                first_byte <= 1'b0;
                remain     <= need[3:0];
                idx        <= '0;
            end
            if (state == ST_PARAM && wr_acc) begin
                remain    <= remain - 1'b1;
                idx       <= idx + 1'b1;
                parm_stb  <= 1'b1;
                parm_data <= hst_wdata;
                parm_idx  <= idx;
            end
        end
    end

    // outputs from state
    always_comb begin
        rqm        = 1'b0;
        dio        = 1'b0;
        busy       = 1'b1;
        ndm        = 1'b0;
        fifo_allow = 1'b0;
        unique case (state)
            ST_IDLE:   begin rqm = 1'b1; busy = 1'b0; end
            ST_ABSORB: ;
            ST_PARAM:  rqm = 1'b1;
            ST_EXEC:   begin ndm = nondma_mode; fifo_allow = 1'b1; end
            ST_INVAL:  begin rqm = 1'b1; dio = 1'b1; end
            default:   ;
        endcase
    end
endmodule

// File: rtl/fdc_cmd_handshake_chk.sv
module fdc_cmd_handshake_chk (
    input logic clk,
    input logic rst_n,
    input logic rqm,
    input logic dio,
    input logic busy,
    input logic wr_acc,
    input logic rd_acc,
    input logic fifo_allow,
    input logic exec_go
);
    // R3
    rqm_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_acc |=> (!rqm && busy));

    // R4
    rqm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rqm) |=> !rqm);

    // R6
    handoff_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exec_go |-> (!rqm && !dio && busy));

    // R7
    fifo_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rqm |-> !fifo_allow);

    // R9
    inval_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_acc |=> !busy);

    // R2
    busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_acc));
endmodule

bind fdc_cmd_handshake fdc_cmd_handshake_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rqm        (rqm),
    .dio        (dio),
    .busy       (busy),
    .wr_acc     (wr_acc),
    .rd_acc     (rd_acc),
    .fifo_allow (fifo_allow),
    .exec_go    (exec_go)
);

// File: tb/fdc_cmd_handshake_tb.sv
`timescale 1ns/1ps
module fdc_cmd_handshake_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hst_addr = 1'b0, hst_rd = 1'b0, hst_wr = 1'b0;
    logic [7:0] hst_wdata = '0;
    logic [7:0] hst_rdata;
    logic       nondma_mode = 1'b0, exec_done = 1'b0;
    logic       exec_go, parm_stb, fifo_allow;
    logic [7:0] exec_opcode, parm_data;
    logic [3:0] parm_idx;

    int checks = 0, errors = 0;
    logic [8:0] sb[$];   // {is_handoff, byte}
    bit done_flag = 0;

    always #2 clk = ~clk;

    fdc_cmd_handshake u_dut (
        .clk(clk), .rst_n(rst_n), .hst_addr(hst_addr), .hst_rd(hst_rd),
        .hst_wr(hst_wr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
        .nondma_mode(nondma_mode), .exec_done(exec_done), .exec_go(exec_go),
        .exec_opcode(exec_opcode), .parm_stb(parm_stb), .parm_data(parm_data),
        .parm_idx(parm_idx), .fifo_allow(fifo_allow)
    );

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops expected items as the design emits them (R5, R6)
    always @(negedge clk) begin
        if (rst_n && (parm_stb || exec_go)) begin
            logic [8:0] got;
            got = exec_go ? {1'b1, exec_opcode} : {1'b0, parm_data};
            if (sb.size() == 0) check("R2 unexpected output", got, 9'h1FF);
            else check("R5/R6 stream", got, sb.pop_front());
        end
    end

    task automatic status_is(input string req, input logic [7:0] exp);
        hst_addr = 1'b0; #1;
        check(req, {1'b0, hst_rdata}, {1'b0, exp});
    endtask

    task automatic hwrite(input logic a, input logic [7:0] d);
        @(negedge clk); hst_addr = a; hst_wdata = d; hst_wr = 1'b1;
        @(negedge clk); hst_wr = 1'b0;
    endtask

    task automatic push_parm(input logic [7:0] d); sb.push_back({1'b0, d}); endtask
    task automatic push_go(input logic [7:0] d);   sb.push_back({1'b1, d}); endtask

    // write a byte and check the ready timing (R3, R4): ends two clocks later
    task automatic send(input logic [7:0] d, input logic more);
        hwrite(1'b1, d);
        status_is("R3 ready low after write", 8'h10);
        @(negedge clk); status_is("R4 ready still low", 8'h10);
        @(negedge clk);
        if (more) status_is("R4 ready back", 8'h90);
    endtask

    initial begin
        #(4 * 200000);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        status_is("R1 reset status", 8'h80);
        check("R7 fifo in reset", {8'h0, fifo_allow}, 9'h0);
        rst_n = 1'b1;
        @(negedge clk);
        status_is("R1 idle status", 8'h80);

        // R2: status-port write ignored
        hwrite(1'b0, 8'h03);
        status_is("R2 status write ignored", 8'h80);

        // specify with a write during latency that must be ignored
        send(8'h03, 1'b1);
        check("R7 fifo off in param", {8'h0, fifo_allow}, 9'h0);
        push_parm(8'h11);
        hwrite(1'b1, 8'h11);
        hwrite(1'b1, 8'h99);      // lands during absorb: ignored (R2)
        @(negedge clk);
        status_is("R4 ready after param", 8'h90);
        push_parm(8'h22); push_go(8'h03);
        send(8'h22, 1'b0);
        status_is("R6 exec status", 8'h10);
        check("R7 fifo in exec", {8'h0, fifo_allow}, 9'h1);
        nondma_mode = 1'b1; #1;
        status_is("R8 non-DMA bit", 8'h30);
        hwrite(1'b1, 8'h55);      // ignored during exec (R2)
        status_is("R2 exec write ignored", 8'h30);
        nondma_mode = 1'b0;
        @(negedge clk); exec_done = 1'b1;
        @(negedge clk); exec_done = 1'b0;
        status_is("R10 back to idle", 8'h80);

        // R9: invalid opcode
        send(8'h1F, 1'b0);
        status_is("R9 invalid status", 8'hD0);
        check("R7 fifo off invalid", {8'h0, fifo_allow}, 9'h0);
        hst_addr = 1'b1; #1;
        check("R9 invalid byte", {1'b0, hst_rdata}, 9'h080);
        @(negedge clk); hst_rd = 1'b1;
        @(negedge clk); hst_rd = 1'b0;
        status_is("R9 returns idle", 8'h80);

        // R11: zero-parameter command
        push_go(8'h08);
        send(8'h08, 1'b0);
        status_is("R11 straight to exec", 8'h10);
        @(negedge clk); exec_done = 1'b1;
        @(negedge clk); exec_done = 1'b0;

        // R5: eight-parameter command with mode bits set
        send(8'hE6, 1'b1);
        for (int i = 0; i < 8; i++) begin
            push_parm(8'(i * 17 + 3));
            if (i == 7) push_go(8'hE6);
            send(8'(i * 17 + 3), i != 7);
            check("R7 fifo per param", {8'h0, fifo_allow}, {8'h0, i == 7});
        end
        status_is("R6 exec after eight", 8'h10);
        @(negedge clk); exec_done = 1'b1;
        @(negedge clk); exec_done = 1'b0;
        status_is("R10 idle again", 8'h80);

        repeat (3) @(negedge clk);
        check("R5 scoreboard drained", 9'(sb.size()), 9'd0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule